// File: doc/BRIEF.md
# Mode-Dependent Shared Address/GPIO Port

This block controls eight chip pins. Each pin is a general-purpose input, a general-purpose output, or a line of the external address bus. The choice depends on a 3-bit operating-mode input and, in some modes, on a per-pin direction bit. Software sees four byte-wide registers on a simple peripheral bus: a direction register, an output-data register, a pin-level register and a pull-up control register. Reads are combinational while the read strobe is high. Writes land on the next clock edge.

For each pin the block produces an output enable, an output value and a pull-up enable, and the pad logic outside uses them directly. The external address comes in as a vector and is only steered onto pins here. Reset and low-power events act on the registers in different ways:
- Power-on reset and hardware standby clear all three writable registers.
- A manual reset keeps the direction and data contents.
- Software standby keeps everything. A hold input then decides whether address pins freeze at their last value or float.

Top module: `addr_gpio_port`

## Requirements
- R1: A write strobe with an address that matches a register updates that register on the next clock edge. The register addresses are: data 0xFF6B, direction 0xFEBB, pull-up 0xFF72, pin-level 0xFF5B (read-only). The data and pull-up registers read back what was written.
- R2: After power-on reset (active-low `rst_n`), the direction, data and pull-up registers are all 0x00.
- R3: While `hw_stby` is high, every output enable and pull-up enable is 0 and every pin output is 0. The direction, data and pull-up registers are cleared on each clock edge with `hw_stby` high.
- R4: A clock edge with `man_rst` high keeps the direction and data registers, clears the pull-up register and ignores any write in that cycle.
- R5: During software standby (`sw_stby` high), all registers keep their contents and bus writes are ignored.
- R6: In mode 7, a pin whose direction bit is 1 is driven (enable 1) with its data-register bit. A pin whose direction bit is 0 is an input (enable 0, output 0).
- R7: In mode 6, a pin whose direction bit is 1 drives the matching `addr_in` bit. A pin whose direction bit is 0 is an input.
- R8: In modes 4 and 5, every pin drives its `addr_in` bit whatever the direction register holds.
- R9: In software standby, address pins with `stby_hold` = 1 keep driving the address value sampled on the last clock edge before standby. With `stby_hold` = 0 they are released (enable 0, output 0). General-purpose output pins keep driving their data bit.
- R10: A read of the pin-level register returns the data-register bit for general-purpose output pins. For every other pin it returns the `pin_in` level as captured two clock edges earlier.
- R11: A pull-up enable is 1 only on a pin that is an input in the current mode and whose pull-up bit is 1.
- R12: In modes 0 to 3, every pin is an input.
- R13: With `bus_rd` low, or with an address that matches no register, `bus_rdata` is 0x00. A read of the direction register returns a fixed pattern with no defined meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low; asserted asynchronously, released synchronously |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| hw_stby | input | 1 | Hardware standby, active high |
| sw_stby | input | 1 | Software standby, active high |
| stby_hold | input | 1 | Keep address pins driven during software standby |
| mode | input | 3 | Operating mode |
| bus_addr | input | 16 | Register address (low 16 bits) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| addr_in | input | 8 | External address bits to place on the pins |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
The bench drives the same pins through each mode while the direction register holds a mixed pattern. A design that ignored the direction bits in modes 4 and 5, or honoured them in modes 0 to 3, would show the wrong enables straight away.

Entering software standby while `addr_in` is changing separates a correct hold register from one that samples one cycle too late. Such a design would show the new address instead of the frozen one. Writes issued during standby and during a manual reset must leave the readback unchanged, and a manual reset must clear only the pull-up bits. The pin-level register is read both one and several cycles after a pin change, which exposes a synchronizer with the wrong depth and a read path that returns the pad level for output pins.

// File: rtl/agp_pkg.sv
package agp_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ROLE_INPUT = 2'd0,
    ROLE_GPIO  = 2'd1,
    ROLE_ADDR  = 2'd2
  } pin_role_e;

  localparam logic [MODE_W-1:0] MODE_EXT_A = 3'd4;
  localparam logic [MODE_W-1:0] MODE_EXT_B = 3'd5;
  localparam logic [MODE_W-1:0] MODE_MIXED = 3'd6;
  localparam logic [MODE_W-1:0] MODE_PORT  = 3'd7;

  // Per-pin role from the operating mode and the pin's direction bit.
  function automatic pin_role_e role_of(input logic [MODE_W-1:0] mode,
                                        input logic dir_bit);
    pin_role_e r;
    case (mode)
      MODE_EXT_A, MODE_EXT_B: r = ROLE_ADDR;
      MODE_MIXED:             r = dir_bit ? ROLE_ADDR : ROLE_INPUT;
      MODE_PORT:              r = dir_bit ? ROLE_GPIO : ROLE_INPUT;
      default:                r = ROLE_INPUT;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/agp_rst_sync.sv
module agp_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) stage_q <= 2'b00;
    else              stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/agp_sync.sv
module agp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d;
  logic [W-1:0] sync_d;

  always_comb begin
    meta_d = async_in;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  // Settling counter so the latency check only looks at cycles since reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R10: the synchronized level is the input from two edges earlier.
  p_sync_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (sync_q == $past(async_in, 2)));
endmodule

// File: rtl/agp_regs.sv
module agp_regs #(
  parameter int              W        = 8,
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   ADR_DIR  = 16'hFEBB,
  parameter logic [AW-1:0]   ADR_DATA = 16'hFF6B,
  parameter logic [AW-1:0]   ADR_PULL = 16'hFF72
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          man_rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  pull_q
);
  logic [W-1:0] dir_d, data_d, pull_d;
  logic         wr_ok;
  logic         dir_en, data_en, pull_en;

  assign wr_ok = bus_wr & ~sw_stby & ~hw_stby & ~man_rst;

  always_comb begin
    dir_d   = dir_q;
    data_d  = data_q;
    pull_d  = pull_q;
    dir_en  = 1'b0;
    data_en = 1'b0;
    pull_en = 1'b0;
    if (hw_stby) begin
      dir_d   = '0;
      data_d  = '0;
      pull_d  = '0;
      dir_en  = 1'b1;
      data_en = 1'b1;
      pull_en = 1'b1;
    end else if (man_rst) begin
      pull_d  = '0;
      pull_en = 1'b1;
    end else if (wr_ok) begin
      if (bus_addr == ADR_DIR) begin
        dir_d  = bus_wdata;
        dir_en = 1'b1;
      end
      if (bus_addr == ADR_DATA) begin
        data_d  = bus_wdata;
        data_en = 1'b1;
      end
      if (bus_addr == ADR_PULL) begin
        pull_d  = bus_wdata;
        pull_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
      pull_q <= '0;
    end else begin
      if (dir_en)  dir_q  <= dir_d;
      if (data_en) data_q <= data_d;
      if (pull_en) pull_q <= pull_d;
    end
  end

  p_write_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_DATA && !sw_stby && !hw_stby && !man_rst)
      |=> (data_q == $past(bus_wdata)));

  p_hw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == '0 && data_q == '0 && pull_q == '0));

  p_mrst_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (man_rst && !hw_stby) |=> (dir_q == $past(dir_q) && data_q == $past(data_q)
                               && pull_q == '0));

  p_stby_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby && !man_rst)
      |=> ($stable(dir_q) && $stable(data_q) && $stable(pull_q)));
endmodule

// File: rtl/agp_pin_ctrl.sv
module agp_pin_ctrl
  import agp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              stby_hold,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      data_q,
  input  logic [W-1:0]      pull_q,
  input  logic [W-1:0]      addr_in,
  input  logic [W-1:0]      pins_sync,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_pu,
  output logic [W-1:0]      pin_level
);
  // Address captured every cycle outside software standby, frozen inside it.
  logic [W-1:0] hold_q, hold_d;
  logic         hold_en;

  assign hold_en = ~sw_stby;
  always_comb hold_d = addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_role_e role;
    logic      oe_b, out_b, pu_b;

    assign role = role_of(mode, dir_q[i]);

    always_comb begin
      oe_b  = 1'b0;
      out_b = 1'b0;
      pu_b  = 1'b0;
      if (!hw_stby) begin
        case (role)
          ROLE_GPIO: begin
            oe_b  = 1'b1;
            out_b = data_q[i];
          end
          ROLE_ADDR: begin
            if (!sw_stby) begin
              oe_b  = 1'b1;
              out_b = addr_in[i];
            end else if (stby_hold) begin
              oe_b  = 1'b1;
              out_b = hold_q[i];
            end
          end
          default: pu_b = pull_q[i];
        endcase
      end
    end

    assign pin_oe[i]    = oe_b;
    assign pin_out[i]   = out_b;
    assign pin_pu[i]    = pu_b;
    assign pin_level[i] = (role == ROLE_GPIO) ? data_q[i] : pins_sync[i];
  end

  p_hw_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (pin_oe == '0 && pin_pu == '0 && pin_out == '0));

  p_pu_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_pu) == '0);

  p_ext_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_EXT_A || mode == MODE_EXT_B) && !sw_stby && !hw_stby)
      |-> (pin_oe == '1 && pin_out == addr_in));

  p_low_modes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode < MODE_EXT_A) |-> (pin_oe == '0));

  p_hold_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sw_stby) && stby_hold && !hw_stby && mode == MODE_EXT_A)
      |-> (pin_out == $past(addr_in)));
endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
  import agp_pkg::*;
#(
  parameter int            W           = 8,
  parameter int            AW          = 16,
  parameter logic [AW-1:0] ADR_DIR     = 16'hFEBB,
  parameter logic [AW-1:0] ADR_DATA    = 16'hFF6B,
  parameter logic [AW-1:0] ADR_LEVEL   = 16'hFF5B,
  parameter logic [AW-1:0] ADR_PULL    = 16'hFF72,
  parameter logic [W-1:0]  DIR_RD_FILL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              stby_hold,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      addr_in,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_pu
);
  logic         rst_int_n;
  logic [W-1:0] dir_q, data_q, pull_q;
  logic [W-1:0] pins_sync, pin_level;

  agp_rst_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  agp_regs #(
    .W        (W),
    .AW       (AW),
    .ADR_DIR  (ADR_DIR),
    .ADR_DATA (ADR_DATA),
    .ADR_PULL (ADR_PULL)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .man_rst   (man_rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .pull_q    (pull_q)
  );

  agp_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pin_in),
    .sync_q   (pins_sync)
  );

  agp_pin_ctrl #(.W(W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode      (mode),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .stby_hold (stby_hold),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .pull_q    (pull_q),
    .addr_in   (addr_in),
    .pins_sync (pins_sync),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_pu    (pin_pu),
    .pin_level (pin_level)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADR_DATA:  bus_rdata = data_q;
        ADR_LEVEL: bus_rdata = pin_level;
        ADR_PULL:  bus_rdata = pull_q;
        ADR_DIR:   bus_rdata = DIR_RD_FILL;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R13: an idle bus returns zero.
  p_idle_bus_r13: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/addr_gpio_port_tb.sv
module addr_gpio_port_tb;
  localparam logic [15:0] A_DIR  = 16'hFEBB;
  localparam logic [15:0] A_DATA = 16'hFF6B;
  localparam logic [15:0] A_LVL  = 16'hFF5B;
  localparam logic [15:0] A_PULL = 16'hFF72;

  logic        clk = 1'b0;
  logic        rst_n, man_rst, hw_stby, sw_stby, stby_hold;
  logic [2:0]  mode;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata, addr_in, pin_in, pin_oe, pin_out, pin_pu;

  always #5 clk = ~clk;

  addr_gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .stby_hold(stby_hold), .mode(mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .addr_in(addr_in),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R2";
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;

  // Behavioural reference state.
  logic [7:0] m_dir, m_data, m_pull, m_s1, m_s2, m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_data = 0; m_pull = 0; m_s1 = 0; m_s2 = 0; m_hold = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (!sw_stby) m_hold = addr_in;
      if (hw_stby) begin
        m_dir = 0; m_data = 0; m_pull = 0;
      end else if (man_rst) begin
        m_pull = 0;
      end else if (bus_wr && !sw_stby) begin
        if (bus_addr == A_DIR)  m_dir  = bus_wdata;
        if (bus_addr == A_DATA) m_data = bus_wdata;
        if (bus_addr == A_PULL) m_pull = bus_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against the model on each falling edge.
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [7:0] e_oe, e_out, e_pu, e_lvl, e_rd;
      e_oe = 0; e_out = 0; e_pu = 0; e_lvl = 0; e_rd = 0;
      for (int i = 0; i < 8; i++) begin
        int role; // 0 input, 1 port output, 2 address
        if (mode == 4 || mode == 5) role = 2;
        else if (mode == 6)         role = m_dir[i] ? 2 : 0;
        else if (mode == 7)         role = m_dir[i] ? 1 : 0;
        else                        role = 0;
        e_lvl[i] = (role == 1) ? m_data[i] : m_s2[i];
        if (!hw_stby) begin
          if (role == 1) begin
            e_oe[i] = 1; e_out[i] = m_data[i];
          end else if (role == 2) begin
            if (!sw_stby) begin e_oe[i] = 1; e_out[i] = addr_in[i]; end
            else if (stby_hold) begin e_oe[i] = 1; e_out[i] = m_hold[i]; end
          end else e_pu[i] = m_pull[i];
        end
      end
      chk({cur_req, " oe"}, pin_oe, e_oe);
      chk({cur_req, " out"}, pin_out, e_out);
      chk({cur_req, " pu"}, pin_pu, e_pu);
      if (!(bus_rd && bus_addr == A_DIR)) begin
        if (bus_rd) begin
          if (bus_addr == A_DATA)      e_rd = m_data;
          else if (bus_addr == A_LVL)  e_rd = e_lvl;
          else if (bus_addr == A_PULL) e_rd = m_pull;
        end
        chk({cur_req, " rdata"}, bus_rdata, e_rd);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    step(1);
    bus_wr = 0;
  endtask

  // Hold a read for one cycle and sample it directly.
  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    chk(req, bus_rdata, exp);
    step(1);
    bus_rd = 0;
  endtask

  task automatic see(input string req, input logic [7:0] oe, input logic [7:0] o,
                     input logic [7:0] pu);
    @(negedge clk);
    chk({req, " oe"}, pin_oe, oe);
    chk({req, " out"}, pin_out, o);
    chk({req, " pu"}, pin_pu, pu);
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; man_rst = 0; hw_stby = 0; sw_stby = 0; stby_hold = 0;
    mode = 3'd7; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    addr_in = 0; pin_in = 0;
    step(3);
    rst_n = 1;
    step(4);
    cmp_en = 1;

    cur_req = "R2";
    rd_chk("R2 data", A_DATA, 8'h00);
    rd_chk("R2 pull", A_PULL, 8'h00);
    see("R2", 8'h00, 8'h00, 8'h00);

    cur_req = "R1";
    wr(A_DIR, 8'hF0);
    wr(A_DATA, 8'hA5);
    wr(A_PULL, 8'h0F);
    rd_chk("R1 data", A_DATA, 8'hA5);
    rd_chk("R1 pull", A_PULL, 8'h0F);

    cur_req = "R6";
    see("R6", 8'hF0, 8'hA0, 8'h0F);

    cur_req = "R10";
    pin_in = 8'h3C;
    rd_chk("R10 early", A_LVL, 8'hA0);
    step(2);
    rd_chk("R10 settled", A_LVL, 8'hAC);

    cur_req = "R11";
    wr(A_PULL, 8'h33);
    see("R11", 8'hF0, 8'hA0, 8'h03);

    cur_req = "R7";
    addr_in = 8'h5A; mode = 3'd6;
    see("R7", 8'hF0, 8'h50, 8'h03);

    cur_req = "R8";
    wr(A_DIR, 8'h00);
    mode = 3'd4;
    see("R8 m4", 8'hFF, 8'h5A, 8'h00);
    mode = 3'd5; addr_in = 8'hE1;
    see("R8 m5", 8'hFF, 8'hE1, 8'h00);

    cur_req = "R12";
    mode = 3'd2;
    see("R12", 8'h00, 8'h00, 8'h33);

    cur_req = "R9";
    mode = 3'd4; addr_in = 8'hC3; stby_hold = 1;
    step(2);
    sw_stby = 1; addr_in = 8'h11;
    see("R9 hold", 8'hFF, 8'hC3, 8'h00);
    stby_hold = 0;
    see("R9 float", 8'h00, 8'h00, 8'h00);

    cur_req = "R5";
    wr(A_DATA, 8'h0F);
    wr(A_PULL, 8'hFF);
    sw_stby = 0;
    step(1);
    rd_chk("R5 data", A_DATA, 8'hA5);
    rd_chk("R5 pull", A_PULL, 8'h33);

    cur_req = "R4";
    mode = 3'd7;
    wr(A_DIR, 8'h0F);
    man_rst = 1; bus_addr = A_DATA; bus_wdata = 8'h00; bus_wr = 1;
    step(1);
    man_rst = 0; bus_wr = 0;
    rd_chk("R4 data", A_DATA, 8'hA5);
    rd_chk("R4 pull", A_PULL, 8'h00);
    see("R4 dir", 8'h0F, 8'h05, 8'h00);

    cur_req = "R13";
    rd_chk("R13 unmapped", 16'h1234, 8'h00);
    bus_addr = A_DIR; bus_rd = 1;
    step(1);
    bus_rd = 0;
    bus_addr = A_DATA;
    @(negedge clk);
    chk("R13 idle", bus_rdata, 8'h00);
    step(1);

    cur_req = "R3";
    wr(A_PULL, 8'hF0);
    hw_stby = 1;
    see("R3 active", 8'h00, 8'h00, 8'h00);
    hw_stby = 0;
    rd_chk("R3 data", A_DATA, 8'h00);
    rd_chk("R3 pull", A_PULL, 8'h00);
    see("R3 after", 8'h00, 8'h00, 8'h00);

    step(2);
    cmp_en = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule